// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Aggregator

This block merges the interrupt requests of four serial-port channels into one 32-bit status word. A host fetches the whole word in a single access. The word offers two views of the same state. The low byte holds one request flag per channel. Above it sit packed 3-bit cause codes, one per channel, and each code names the most urgent pending source of its channel. The host can branch on the flag byte to reach a channel quickly, or decode every channel's cause from the same read.

Each channel presents five level-sensitive pending conditions and a one-cycle pulse that marks a read of that channel's own status register. The serial engines clear their pending levels themselves after such a read. The block also watches a per-channel sleep level. When every channel has been asleep and then any one wakes, a device-wide wake event is latched. It is reported through channel 0 and cleared by channel 0's read pulse. The status word is returned on a small request/valid read port. The port never applies back-pressure: each accepted `rd_req` produces exactly one `rd_valid` beat on the next cycle, the host must take that beat, and `rd_data` holds its value until the next request. Fetching the word changes no state.

Top module: `irq_status_agg`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rd_valid` is 0 and `rd_data` is all zeros. Reset also clears the wake latch.
- R2: Bits 7:4 and bits 31:20 of every returned word are always zero.
- R3: Bit c of the word (c = 0..3) is 1 exactly when any of channel c's five pending inputs `ch_src[5c+4:5c]` is high. For channel 0 the latched wake event also sets the bit.
- R4: Channel c's cause code sits at bits `8+3c+2 : 8+3c`. Its flag bit is 1 exactly when that code is nonzero.
- R5: Within a channel's 5-bit group, bit 0 is line status (code 1), bit 1 is receive data (code 2), bit 2 is receive timeout (code 3), bit 3 is transmit empty (code 4) and bit 4 is modem status (code 5). The code reports the highest-priority pending source, and priority follows that same order with line status highest. Code 0 means nothing is pending.
- R6: A high `rd_req` sampled at a clock edge gives `rd_valid` = 1 on the following cycle, with `rd_data` equal to the word at that edge. Otherwise `rd_valid` is 0 and `rd_data` keeps its value.
- R7: If `ch_sleep` is all ones at one edge and not all ones at the next, the wake latch sets. While it is set, channel 0 reports code 6, unless one of channel 0's own sources is pending, since those all rank above it.
- R8: The wake latch clears only on a `ch_rd[0]` pulse. Pulses on other channels leave it set, and a sleep pattern that does not include every channel never sets it.
- R9: Fetching the word through `rd_req` has no side effect. Back-to-back fetches with unchanged inputs return identical words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_src | input | 20 | Pending source levels, 5 per channel, channel c at bits 5c+4:5c |
| ch_rd | input | 4 | One-cycle pulse per channel: its status register was read |
| ch_sleep | input | 4 | Per-channel sleep level |
| rd_req | input | 1 | Request to fetch the status word |
| rd_valid | output | 1 | Returned word is valid this cycle |
| rd_data | output | 32 | Returned status word |

## Verification
The checker assumes that `ch_rd` arrives as single-cycle pulses and that `ch_sleep` and `ch_src` change only at clock edges. It also assumes the host does not rely on back-pressure, because the port accepts every request. The bench drives all inputs on the falling edge and keeps each read pulse to one cycle. It holds the sleep pattern for at least one full edge before changing it, so that the armed state the wake rule depends on is always established. Single-pulse reads mean a wake clear never overlaps a new wake event, except where a test creates that overlap on purpose.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned SRC_W  = 5;
  localparam int unsigned CODE_W = 3;

  // Source bit positions within one channel's group (priority order)
  localparam int unsigned SRC_LINE   = 0;
  localparam int unsigned SRC_RXDATA = 1;
  localparam int unsigned SRC_RXTMO  = 2;
  localparam int unsigned SRC_TXMT   = 3;
  localparam int unsigned SRC_MODEM  = 4;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_LINE   = 3'd1,
    CAUSE_RXDATA = 3'd2,
    CAUSE_RXTMO  = 3'd3,
    CAUSE_TXMT   = 3'd4,
    CAUSE_MODEM  = 3'd5,
    CAUSE_WAKE   = 3'd6
  } cause_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_agg_pkg::*;
(
  input  logic [SRC_W-1:0]  src,
  input  logic              wake,
  output logic [CODE_W-1:0] code,
  output logic              flag
);
  cause_e cause;

  always_comb begin
    if (src[SRC_LINE])        cause = CAUSE_LINE;
    else if (src[SRC_RXDATA]) cause = CAUSE_RXDATA;
    else if (src[SRC_RXTMO])  cause = CAUSE_RXTMO;
    else if (src[SRC_TXMT])   cause = CAUSE_TXMT;
    else if (src[SRC_MODEM])  cause = CAUSE_MODEM;
    else if (wake)            cause = CAUSE_WAKE;
    else                      cause = CAUSE_NONE;
  end

  assign code = cause;
  assign flag = (|src) | wake;
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sleep,
  input  logic              clr,
  output logic              armed,
  output logic              pend
);
  logic all_asleep;
  logic fire;

  assign all_asleep = &sleep;
  assign fire       = armed & ~all_asleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      armed <= all_asleep;
      if (fire)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned CODE_BASE = 8,
  parameter int unsigned WAKE_CH   = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*SRC_W-1:0] ch_src,
  input  logic [NUM_CH-1:0]       ch_rd,
  input  logic [NUM_CH-1:0]       ch_sleep,
  input  logic                    rd_req,
  output logic                    rd_valid,
  output logic [WORD_W-1:0]       rd_data
);
  localparam int unsigned CODE_TOP = CODE_BASE + NUM_CH * CODE_W;

  logic              wake_armed;
  logic              wake_pend;
  logic [NUM_CH-1:0] flags;
  logic [WORD_W-1:0] word;

  irq_wake_det #(.NUM_CH(NUM_CH)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .sleep (ch_sleep),
    .clr   (ch_rd[WAKE_CH]),
    .armed (wake_armed),
    .pend  (wake_pend)
  );

  always_comb begin
    word = '0;
    word[NUM_CH-1:0] = flags;
    for (int c = 0; c < NUM_CH; c++) begin
      word[CODE_BASE + c*CODE_W +: CODE_W] = codes[c];
    end
  end

  logic [CODE_W-1:0] codes [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_prio_enc u_enc (
      .src  (ch_src[c*SRC_W +: SRC_W]),
      .wake ((c == WAKE_CH) ? wake_pend : 1'b0),
      .code (codes[c]),
      .flag (flags[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= word;
    end
  end

  if (CODE_TOP > WORD_W) begin : g_bad_layout
    initial $error("code fields exceed word width");
  end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned CODE_BASE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_rd,
  input logic [NUM_CH-1:0] ch_sleep,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_data,
  input logic              wake_pend
);
  localparam int unsigned CODE_TOP = CODE_BASE + NUM_CH * 3;

  // R2: reserved bits never set
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[CODE_BASE-1:NUM_CH] == '0 && rd_data[WORD_W-1:CODE_TOP] == '0));

  // R4: flag agrees with its code field
  for (genvar c = 0; c < NUM_CH; c++) begin : g_fc
    p_flag_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_data[c] == (rd_data[CODE_BASE + c*3 +: 3] != 3'd0)));
  end

  // R6: one valid beat per request
  p_valid_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_no_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));

  // R7: wake latch sets after leaving an all-asleep state
  p_wake_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&ch_sleep) ##1 !(&ch_sleep)) |=> wake_pend);

  // R8: clear on channel-0 read only
  p_wake_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd[0] && (&ch_sleep)) |=> !wake_pend);
  p_wake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pend && !ch_rd[0] && (|ch_rd[NUM_CH-1:1])) |=> wake_pend);
endmodule

bind irq_status_agg irq_status_agg_chk #(
  .NUM_CH(NUM_CH), .WORD_W(WORD_W), .CODE_BASE(CODE_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_rd     (ch_rd),
  .ch_sleep  (ch_sleep),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .wake_pend (wake_pend)
);

// File: tb/irq_status_agg_test.sv
`timescale 1ns/1ps
module irq_status_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] ch_src = '0;
  logic [3:0]  ch_rd = '0;
  logic [3:0]  ch_sleep = '0;
  logic        rd_req = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_status_agg uut (
    .clk(clk), .rst_n(rst_n), .ch_src(ch_src), .ch_rd(ch_rd),
    .ch_sleep(ch_sleep), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {source vector, expected word}
  localparam logic [51:0] VEC [8] = '{
    {20'h00000, 32'h00000000},   // R3 nothing pending
    {20'h00001, 32'h00000101},   // R5 ch0 line
    {20'h00200, 32'h00002802},   // R5 ch1 modem
    {20'h06000, 32'h00010004},   // R5 ch2 txempty over modem
    {20'h60000, 32'h00060008},   // R5 ch3 rxtmo over txempty
    {20'h00006, 32'h00000201},   // R5 ch0 rxdata over rxtmo
    {20'hFFFFF, 32'h0002490F},   // R4 all channels, line wins
    {20'h88040, 32'h0002100A}    // R3 mixed channels
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic fetch(output logic [31:0] d, output logic v);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    d = rd_data;
    v = rd_valid;
  endtask

  task automatic pulse_rd(input logic [3:0] m);
    @(negedge clk) ch_rd = m;
    @(negedge clk) ch_rd = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic v;

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, rd_valid}, 32'd0);
    chk("R1 data in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, rd_valid}, 32'd0);
    chk("R1 data after reset", rd_data, 32'd0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk) ch_src = VEC[i][51:32];
      fetch(d, v);
      chk("R6 valid beat", {31'd0, v}, 32'd1);
      chk("R3 R4 R5 vector word", d, VEC[i][31:0]);
      chk("R2 reserved bits", d & 32'hFFF000F0, 32'd0);
    end

    // R6: valid drops, data holds
    @(negedge clk) ch_src = 20'h00001;
    chk("R6 valid idle", {31'd0, rd_valid}, 32'd0);
    chk("R6 data held", rd_data, 32'h0002100A);
    ch_src = '0;

    // R8: partial sleep produces no wake
    @(negedge clk) ch_sleep = 4'b0111;
    @(negedge clk); @(negedge clk) ch_sleep = 4'b0000;
    @(negedge clk);
    fetch(d, v);
    chk("R8 partial sleep no wake", d, 32'd0);

    // R7: full sleep then wake
    @(negedge clk) ch_sleep = 4'b1111;
    @(negedge clk); @(negedge clk) ch_sleep = 4'b0100;
    @(negedge clk) ch_sleep = 4'b0000;
    fetch(d, v);
    chk("R7 wake code", d, 32'h00000601);
    // R9: second fetch identical
    fetch(d2, v);
    chk("R9 no side effect", d2, d);
    // R7: own source outranks wake
    @(negedge clk) ch_src = 20'h00010;
    fetch(d, v);
    chk("R7 modem over wake", d, 32'h00000501);
    ch_src = '0;
    // R8: other channel reads keep wake
    pulse_rd(4'b1110);
    fetch(d, v);
    chk("R8 other read keeps wake", d, 32'h00000601);
    // R8: channel 0 read clears
    pulse_rd(4'b0001);
    fetch(d, v);
    chk("R8 ch0 read clears", d, 32'd0);

    // R1: reset clears latched wake
    @(negedge clk) ch_sleep = 4'b1111;
    @(negedge clk); @(negedge clk) ch_sleep = 4'b0000;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    fetch(d, v);
    chk("R1 reset clears wake", d, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule